// File: doc/BRIEF.md
# Five-Slot Wide-Word Execution Core

This core runs one 140-bit instruction word on every clock edge while `run` is high. Each word is split into five 28-bit operation slots whose position alone fixes the hardware unit that runs them. Slots 0 and 1 feed two integer add/subtract units, slot 2 feeds a multiplier, and slots 3 and 4 feed two load/store units. All five slots read one shared register file of sixteen 32-bit registers and one shared word-addressed data memory.

The hardware does no dependency checking. Every slot of a word sees the register and memory contents from before that word, and the scheduler that builds the words must keep their operations independent. Loops close through a single compare-and-branch encoded in slot 1. Programs are written into an internal instruction store through a write port while the core is paused. Registers can be observed through a one-cycle read port.

Top module: `vliw5_core`

## Requirements
- R1: While `rst` is high on a clock edge, the program counter `pc_o` becomes 0, every register becomes 0 and `dbg_data` becomes 0.
- R2: Register 0 always reads as zero, and any write aimed at register 0 is dropped.
- R3: Slot s occupies word bits [28s+27:28s]. Inside a slot, bits [27:24] are the opcode, [23:20] rd, [19:16] rs, [15:12] rt and [11:0] a signed immediate. Opcodes are decoded by slot position. Slots 0 and 1: 1 ADD rd=rs+rt, 2 SUB rd=rs-rt, 3 ADDI rd=rs+imm. Slot 2: 1 MUL. Slots 3 and 4: 1 LOAD, 2 STORE. Opcode 0, and any opcode that is not listed for a slot, is a no-operation with no effect.
- R4: Every slot reads its source registers as they stood before the word issued, even when another slot of the same word writes them.
- R5: Add-slot results are 32-bit wrap-around. MUL writes the low 32 bits of rs*rt.
- R6: LOAD sets rd = mem[rs+imm]. STORE sets mem[rs+imm] = rt. The sum is taken modulo the data memory depth.
- R7: A load that shares a word with a store to the same address returns the old contents. When both memory slots store to one address, slot 4's data remains.
- R8: With `run` low, no register, memory location or program counter value changes.
- R9: Each issued word advances `pc_o` by one, wrapping at the instruction store depth. Opcode 4 in slot 1 is a branch: if signed rs < imm, `pc_o` is loaded with {rd,rt} (truncated to the counter width). The branch has no delay slot.
- R10: When two slots of one word write the same register, the higher-numbered slot's value is kept.
- R11: `dbg_data` presents, one edge later, the value register `dbg_sel` held before that edge's writes.
- R12: A high `iw_we` on a clock edge stores `iw_data` at instruction index `iw_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Issue one word per edge while high |
| iw_we | input | 1 | Instruction store write enable |
| iw_addr | input | 6 | Instruction store write index |
| iw_data | input | 140 | Instruction word to store |
| dbg_sel | input | 4 | Register to observe |
| dbg_data | output | 32 | Registered value of the observed register |
| pc_o | output | 6 | Program counter |

## Verification
The hardest cases to reach are words whose slots collide. These include a slot reading a register that another slot of the same word overwrites, a load and a store to one address, two stores to one address, two writes to one register, and writes aimed at register 0. The stimulus is a single hand-built program that packs all of these collisions into a few consecutive words. It also includes a counted loop that closes through the branch three times before falling through, and a pause in the middle of the program. A behavioural model in the bench follows the program every cycle, and the final register values are also compared against constants worked out by hand.

// File: rtl/vliw5_pkg.sv
package vliw5_pkg;
  localparam int SLOTS    = 5;
  localparam int SLOT_W   = 28;
  localparam int WORD_W   = SLOTS * SLOT_W;
  localparam int NREG     = 16;
  localparam int RAW      = $clog2(NREG);
  localparam int BR_SLOT  = 1;

  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_ADDI = 4'd3;
  localparam logic [3:0] OP_BLT  = 4'd4;
  localparam logic [3:0] OP_MUL  = 4'd1;
  localparam logic [3:0] OP_LD   = 4'd1;
  localparam logic [3:0] OP_ST   = 4'd2;

  typedef enum logic [1:0] {KIND_ALU, KIND_MUL, KIND_MEM} unit_kind_e;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  rd;
    logic [3:0]  rs;
    logic [3:0]  rt;
    logic [11:0] imm;
  } slot_t;

  function automatic unit_kind_e kind_of(int s);
    if (s < 2)       return KIND_ALU;
    else if (s == 2) return KIND_MUL;
    else             return KIND_MEM;
  endfunction
endpackage

// File: rtl/vliw5_regfile.sv
module vliw5_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  parameter int NRD  = 11,
  parameter int NWR  = 5,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra    [NRD],
  output logic [DW-1:0] rdat  [NRD],
  input  logic [NWR-1:0] we,
  input  logic [AW-1:0] wa    [NWR],
  input  logic [DW-1:0] wd    [NWR]
);
  logic [DW-1:0] regs [NREG];

  // later ports are visited last, so the highest slot wins a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++)
        if (we[w] && wa[w] != '0) regs[wa[w]] <= wd[w];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdat[r] = (ra[r] == '0) ? '0 : regs[ra[r]];
  end
endmodule

// File: rtl/vliw5_unit.sv
module vliw5_unit
  import vliw5_pkg::*;
#(
  parameter int         DW     = 32,
  parameter int         PCW    = 6,
  parameter int         MAW    = 6,
  parameter unit_kind_e KIND   = KIND_ALU,
  parameter bit         HAS_BR = 1'b0
) (
  input  slot_t          ins,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  ld_data,
  output logic           wr_en,
  output logic [DW-1:0]  wr_data,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           br_taken,
  output logic [PCW-1:0] br_target
);
  logic [DW-1:0] simm;
  logic [DW-1:0] ea;

  assign simm      = {{(DW-12){ins.imm[11]}}, ins.imm};
  assign ea        = a + simm;
  assign mem_addr  = ea[MAW-1:0];
  assign mem_wdata = b;
  assign br_target = PCW'({ins.rd, ins.rt});

  always_comb begin
    wr_en    = 1'b0;
    wr_data  = '0;
    mem_we   = 1'b0;
    br_taken = 1'b0;
    case (KIND)
      KIND_ALU: begin
        case (ins.op)
          OP_ADD:  begin wr_en = 1'b1; wr_data = a + b; end
          OP_SUB:  begin wr_en = 1'b1; wr_data = a - b; end
          OP_ADDI: begin wr_en = 1'b1; wr_data = ea;    end
          OP_BLT:  br_taken = HAS_BR && ($signed(a) < $signed(simm));
          default: ;
        endcase
      end
      KIND_MUL: begin
        if (ins.op == OP_MUL) begin wr_en = 1'b1; wr_data = a * b; end
      end
      default: begin
        if (ins.op == OP_LD) begin wr_en = 1'b1; wr_data = ld_data; end
        mem_we = (ins.op == OP_ST);
      end
    endcase
  end
endmodule

// File: rtl/vliw5_dmem.sv
module vliw5_dmem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int NP    = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [NP-1:0] we,
  input  logic [AW-1:0] addr  [NP],
  input  logic [DW-1:0] wdata [NP],
  output logic [DW-1:0] rdata [NP]
);
  logic [DW-1:0] mem [DEPTH];

  // ports in ascending order: the last enabled store to an address remains
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++)
      if (we[p]) mem[addr[p]] <= wdata[p];
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rdata[p] = mem[addr[p]];
  end
endmodule

// File: rtl/vliw5_core.sv
module vliw5_core
  import vliw5_pkg::*;
#(
  parameter int DW          = 32,
  parameter int IMEM_DEPTH  = 64,
  parameter int DMEM_DEPTH  = 64,
  localparam int PCW        = $clog2(IMEM_DEPTH),
  localparam int MAW        = $clog2(DMEM_DEPTH),
  localparam int NRD        = 2 * SLOTS + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              iw_we,
  input  logic [PCW-1:0]    iw_addr,
  input  logic [WORD_W-1:0] iw_data,
  input  logic [RAW-1:0]    dbg_sel,
  output logic [DW-1:0]     dbg_data,
  output logic [PCW-1:0]    pc_o
);
  logic [WORD_W-1:0] imem [IMEM_DEPTH];
  logic [PCW-1:0]    pc;
  logic [WORD_W-1:0] word;

  logic [RAW-1:0]   ra    [NRD];
  logic [DW-1:0]    rdat  [NRD];
  logic [SLOTS-1:0] rf_we;
  logic [RAW-1:0]   rf_wa [SLOTS];
  logic [DW-1:0]    rf_wd [SLOTS];

  logic [SLOTS-1:0] u_wen, u_mwe, u_br, dm_we;
  logic [MAW-1:0]   u_addr [SLOTS];
  logic [DW-1:0]    u_wdat [SLOTS];
  logic [DW-1:0]    u_ld   [SLOTS];
  logic [PCW-1:0]   u_tgt  [SLOTS];

  logic           br_taken;
  logic [PCW-1:0] br_target;

  always_ff @(posedge clk) begin
    if (iw_we) imem[iw_addr] <= iw_data;
  end
  assign word = imem[pc];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    slot_t ins;
    assign ins          = word[s*SLOT_W +: SLOT_W];
    assign ra[2*s]      = ins.rs;
    assign ra[2*s+1]    = ins.rt;
    assign rf_we[s]     = run & u_wen[s];
    assign rf_wa[s]     = ins.rd;
    assign dm_we[s]     = run & u_mwe[s];

    vliw5_unit #(
      .DW(DW), .PCW(PCW), .MAW(MAW),
      .KIND(kind_of(s)), .HAS_BR(s == BR_SLOT)
    ) u_unit (
      .ins(ins), .a(rdat[2*s]), .b(rdat[2*s+1]), .ld_data(u_ld[s]),
      .wr_en(u_wen[s]), .wr_data(rf_wd[s]),
      .mem_we(u_mwe[s]), .mem_addr(u_addr[s]), .mem_wdata(u_wdat[s]),
      .br_taken(u_br[s]), .br_target(u_tgt[s])
    );
  end

  assign ra[NRD-1] = dbg_sel;

  vliw5_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD), .NWR(SLOTS)) u_rf (
    .clk(clk), .rst(rst), .ra(ra), .rdat(rdat),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  vliw5_dmem #(.DW(DW), .DEPTH(DMEM_DEPTH), .NP(SLOTS)) u_dm (
    .clk(clk), .we(dm_we), .addr(u_addr), .wdata(u_wdat), .rdata(u_ld)
  );

  always_comb begin
    br_taken  = 1'b0;
    br_target = '0;
    for (int s = 0; s < SLOTS; s++)
      if (u_br[s]) begin
        br_taken  = 1'b1;
        br_target = u_tgt[s];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      dbg_data <= '0;
    end else begin
      dbg_data <= rdat[NRD-1];
      if (run) pc <= br_taken ? br_target : pc + 1'b1;
    end
  end

  assign pc_o = pc;
endmodule

// File: rtl/vliw5_chk.sv
module vliw5_chk #(
  parameter int DW  = 32,
  parameter int PCW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           run,
  input logic [PCW-1:0] pc,
  input logic           br_taken,
  input logic [PCW-1:0] br_target,
  input logic [3:0]     dbg_sel,
  input logic [DW-1:0]  dbg_data
);
  a_r1_pc_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0);

  a_r8_pause_holds_pc: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc));

  a_r9_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (run && !br_taken) |=> pc == PCW'($past(pc) + 1'b1));

  a_r9_branch_target: assert property (@(posedge clk) disable iff (rst)
    (run && br_taken) |=> pc == $past(br_target));

  a_r2_zero_register: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == 4'd0) |=> dbg_data == '0);
endmodule

bind vliw5_core vliw5_chk #(.DW(DW), .PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .pc(pc_o),
  .br_taken(br_taken), .br_target(br_target),
  .dbg_sel(dbg_sel), .dbg_data(dbg_data)
);

// File: tb/sim_vliw5_core.sv
`timescale 1ns/1ps
module sim_vliw5_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run = 1'b0;
  logic         iw_we = 1'b0;
  logic [5:0]   iw_addr = '0;
  logic [139:0] iw_data = '0;
  logic [3:0]   dbg_sel = '0;
  logic [31:0]  dbg_data;
  logic [5:0]   pc_o;

  always #10 clk = ~clk;

  vliw5_core u0 (.clk(clk), .rst(rst), .run(run), .iw_we(iw_we),
    .iw_addr(iw_addr), .iw_data(iw_data), .dbg_sel(dbg_sel),
    .dbg_data(dbg_data), .pc_o(pc_o));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [139:0] prog [8];
  logic [31:0]  mreg [16];
  logic [31:0]  mmem [64];
  int           mpc;
  logic [31:0]  exp_dbg;

  function automatic logic [27:0] sl(int op, int rd, int rs, int rt, int imm);
    return {op[3:0], rd[3:0], rs[3:0], rt[3:0], imm[11:0]};
  endfunction

  task automatic model_step();
    logic [139:0] w = prog[mpc];
    logic [31:0]  nreg [16];
    logic [31:0]  sd [2];
    int           sa [2];
    bit           sv [2];
    bit           tk = 0;
    int           tgt = 0;
    for (int i = 0; i < 16; i++) nreg[i] = mreg[i];
    for (int s = 0; s < 5; s++) begin
      logic [27:0] f = w[28*s +: 28];
      int op = int'(f[27:24]);
      int rd = int'(f[23:20]);
      logic [31:0] a = (f[19:16] == 0) ? 32'd0 : mreg[f[19:16]];
      logic [31:0] b = (f[15:12] == 0) ? 32'd0 : mreg[f[15:12]];
      logic [31:0] im = {{20{f[11]}}, f[11:0]};
      bit wr = 0;
      logic [31:0] v = 0;
      if (s < 2) begin
        if (op == 1) begin wr = 1; v = a + b; end
        else if (op == 2) begin wr = 1; v = a - b; end
        else if (op == 3) begin wr = 1; v = a + im; end
        else if (op == 4 && s == 1 && $signed(a) < $signed(im)) begin
          tk = 1; tgt = int'({f[23:20], f[15:12]}) % 64;
        end
      end else if (s == 2) begin
        if (op == 1) begin wr = 1; v = a * b; end
      end else begin
        int ad = int'((a + im) % 64);
        sv[s-3] = (op == 2); sa[s-3] = ad; sd[s-3] = b;
        if (op == 1) begin wr = 1; v = mmem[ad]; end
      end
      if (wr && rd != 0) nreg[rd] = v;
    end
    for (int i = 0; i < 16; i++) mreg[i] = nreg[i];
    for (int p = 0; p < 2; p++) if (sv[p]) mmem[sa[p]] = sd[p];
    mpc = tk ? tgt : (mpc + 1) % 64;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      exp_dbg = 0;
      mpc = 0;
      for (int i = 0; i < 16; i++) mreg[i] = 0;
    end else begin
      exp_dbg = (dbg_sel == 0) ? 32'd0 : mreg[dbg_sel];
      if (run) model_step();
    end
  end

  // lockstep comparison on every clock (R9 counter, R11 observation port)
  always @(negedge clk) begin
    if (cmp_en) begin
      check("R9 pc lockstep", 32'(pc_o), 32'(mpc));
      check("R11 dbg lockstep", dbg_data, exp_dbg);
    end
  end

  task automatic read_reg(int r, logic [31:0] exp, string tag);
    dbg_sel = r[3:0];
    @(negedge clk);
    check(tag, dbg_data, exp);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    prog[0] = {sl(3,15,0,0,9), 28'd0, sl(3,15,0,0,9), sl(3,2,0,0,7), sl(3,1,0,0,5)};
    prog[1] = {28'd0, sl(2,0,0,2,3), sl(1,4,1,2,0), sl(3,1,1,0,100), sl(1,3,1,2,0)};
    prog[2] = {sl(2,0,0,1,3), sl(1,7,0,0,3), sl(1,6,3,3,0), 28'd0, sl(2,5,1,3,0)};
    prog[3] = {28'd0, sl(1,8,0,0,3), sl(1,0,1,1,0), sl(3,9,0,0,2), sl(3,9,0,0,-1)};
    prog[4] = {sl(2,0,0,3,9), sl(2,0,0,2,9), 28'd0, 28'd0, sl(3,10,3,0,-20)};
    prog[5] = {sl(1,12,1,0,-96), sl(1,11,0,0,9), 28'd0, 28'd0, 28'd0};
    prog[6] = {28'd0, 28'd0, 28'd0, sl(4,0,13,6,3), sl(3,13,13,0,1)};
    prog[7] = {28'd0, 28'd0, 28'd0, sl(4,0,0,7,1), sl(3,14,0,0,1)};

    repeat (3) @(negedge clk);
    rst = 0;
    cmp_en = 1;
    check("R1 pc after reset", 32'(pc_o), 32'd0);
    read_reg(5, 32'd0, "R1 register cleared");
    read_reg(0, 32'd0, "R2 register 0 after reset");

    // R12: load the program through the write port
    for (int i = 0; i < 8; i++) begin
      iw_we = 1; iw_addr = i[5:0]; iw_data = prog[i];
      @(negedge clk);
    end
    iw_we = 0;

    run = 1;
    repeat (3) @(negedge clk);
    run = 0;
    check("R8 pc at pause", 32'(pc_o), 32'd3);
    repeat (4) @(negedge clk);
    check("R8 pc held while paused", 32'(pc_o), 32'd3);
    read_reg(4, 32'd35, "R8 register held while paused");
    run = 1;
    repeat (14) @(negedge clk);
    run = 0;
    @(negedge clk);

    check("R9 loop exit then self branch", 32'(pc_o), 32'd7);
    read_reg(1, 32'd105, "R5 ADDI result");
    read_reg(2, 32'd7, "R12 program words issued");
    read_reg(3, 32'd12, "R5 ADD result");
    read_reg(4, 32'd35, "R4 multiply saw old r1");
    read_reg(5, 32'd93, "R5 SUB result");
    read_reg(6, 32'd144, "R5 MUL result");
    read_reg(7, 32'd7, "R7 load beside store returns old data");
    read_reg(8, 32'd105, "R6 load after store");
    read_reg(9, 32'd2, "R10 higher slot wins register write");
    read_reg(10, 32'hFFFF_FFF8, "R5 negative immediate wrap");
    read_reg(11, 32'd12, "R7 second memory slot store wins");
    read_reg(12, 32'd12, "R6 negative displacement address");
    read_reg(13, 32'd4, "R9 branch taken three times");
    read_reg(14, 32'd1, "R9 word after loop issued");
    read_reg(15, 32'd0, "R3 opcode foreign to slot is no-op");
    read_reg(0, 32'd0, "R2 write to register 0 dropped");

    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 pc after second reset", 32'(pc_o), 32'd0);
    read_reg(1, 32'd0, "R1 register cleared again");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule